// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master Sequencer

This block runs one transfer at a time on an external asynchronous bus with a 24-bit address and a 16-bit data path. The core presents a request: address, direction, operand size, a 3-bit function code and, for writes, the data to send. The block places the address, function code, size and direction on the bus. It then steps the address strobe, the data strobe and the data output enable through their sequence. After that it waits for the responding device to end the cycle.

The block runs from a double-rate clock, so one `clk` period is one half clock of the bus. A cycle ends when an acknowledge line is asserted, when the bus error input is asserted, or, in interrupt-acknowledge cycles only, when the autovector input is asserted. The block then captures the read data and drops both strobes. It returns the read data together with the responding port width and the error, exception and autovector flags, and marks them with a one-cycle `done` pulse. No new cycle starts until every termination input has been released.

Top module: `abus_master`

## Requirements
- R1: While `rst` is high, and after it is released, `bus_as`, `bus_ds`, `bus_doe` and `done` are low, and `req_ready` is high whenever no termination input is asserted.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. From the next step, `bus_addr`, `bus_fc` and `bus_byte` carry the request's values, and they stay unchanged until the cycle's `done` step. `bus_rw` is 1 for a read and 0 for a write.
- R3: `bus_as` is asserted one step (half bus clock) after the address step, that is, two `clk` edges after the accepting edge.
- R4: In a read, `bus_ds` is asserted in the same step as `bus_as`, and `bus_doe` stays low for the whole cycle.
- R5: In a write, `bus_doe` is asserted one step after `bus_as`, and `bus_ds` is asserted two steps (one full bus clock) after `bus_as`. While `bus_doe` is high, all 16 bits of `bus_dout` equal the request's write data, whatever the operand size.
- R6: Termination is sampled only once all of the cycle's strobes are asserted. The step after termination is sampled keeps both strobes asserted, and `bus_din` is captured at the end of that step. In the step after that, both strobes and `bus_doe` are low, `done` is high for exactly one `clk` cycle, and `rsp_rdata` holds the captured value. After a write, `rsp_rdata` is 0.
- R7: The acknowledge pair `bus_ack[1:0]` uses 1 for an asserted line. A value of 2'b10 reports an 8-bit port (`rsp_port16`=0). A value of 2'b11 or 2'b01 reports a 16-bit port (`rsp_port16`=1).
- R8: `bus_berr` ends the cycle even when no acknowledge arrives, and the response then has `rsp_berr`=1. `rsp_exc` is 1 only when `bus_halt` was asserted together with `bus_berr`.
- R9: An interrupt-acknowledge cycle is a read with function code 3'b111 (CPU space). In such a cycle, `bus_avec` ends the cycle and sets `rsp_avec`=1. In any other cycle, `bus_avec` neither ends the cycle nor sets `rsp_avec`.
- R10: While any of `bus_ack`, `bus_berr` or `bus_avec` is asserted, `req_ready` is low and no new cycle starts, even if `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one period is one half bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_fc | input | 3 | Function code for the cycle |
| req_addr | input | 24 | Address of the most significant byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle pulse: response fields valid |
| rsp_rdata | output | 16 | Captured read data |
| rsp_port16 | output | 1 | Responding port is 16 bits wide |
| rsp_berr | output | 1 | Cycle ended with bus error |
| rsp_exc | output | 1 | Bus error with halt: exception to core |
| rsp_avec | output | 1 | Core must form the vector internally |
| bus_addr | output | 24 | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_byte | output | 1 | Operand size on the bus (1 = byte) |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe, 1 = asserted |
| bus_ds | output | 1 | Data strobe, 1 = asserted |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 2 | Acknowledge pair, also gives port width |
| bus_berr | input | 1 | Bus error termination |
| bus_halt | input | 1 | Halt, read together with bus error |
| bus_avec | input | 1 | Autovector termination |

## Verification
The bus outputs are due at fixed `clk` counts after the accepting edge. The address is due one edge after it and the address strobe two edges after it. In a read, the data strobe comes with the address strobe. In a write, the output enable is due three edges after acceptance and the data strobe four. The captured data and response flags appear with `done`, two edges after the edge that samples the termination. The bench's reference model counts edges from acceptance and from the termination it drives, and it predicts every output for each step. All outputs are compared at the falling edge of `clk`, half a period away from the edge that updates them, so each comparison falls in the step the result is due. Separate directed sequences hold autovector on outside an interrupt-acknowledge cycle, and hold acknowledge on past `done` while a request waits, to show that neither input ends or starts a cycle.

// File: rtl/abus_pkg.sv
package abus_pkg;

    localparam int ABUS_AW  = 24;
    localparam int ABUS_DW  = 16;
    localparam int ABUS_FCW = 3;

    localparam logic [ABUS_FCW-1:0] FC_CPU_SPACE = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASRT,
        ST_WDAT,
        ST_WAIT,
        ST_LATCH,
        ST_END
    } seq_state_t;

    typedef struct packed {
        logic port16;
        logic berr;
        logic exc;
        logic avec;
    } term_t;

    // Any input that can end the current cycle
    function automatic logic term_hit(logic [1:0] ack, logic berr,
                                      logic avec, logic iack);
        return (|ack) || berr || (avec && iack);
    endfunction

    // Status formed from the termination inputs
    function automatic term_t term_decode(logic [1:0] ack, logic berr,
                                          logic halt, logic avec, logic iack);
        term_t t;
        t.port16 = ack[0];
        t.berr   = berr;
        t.exc    = berr && halt;
        t.avec   = avec && iack;
        return t;
    endfunction

endpackage

// File: rtl/abus_req_reg.sv
module abus_req_reg #(
    parameter int AW  = abus_pkg::ABUS_AW,
    parameter int DW  = abus_pkg::ABUS_DW,
    parameter int FCW = abus_pkg::ABUS_FCW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           in_write,
    input  logic           in_byte,
    input  logic [FCW-1:0] in_fc,
    input  logic [AW-1:0]  in_addr,
    input  logic [DW-1:0]  in_wdata,
    output logic           q_write,
    output logic           q_byte,
    output logic [FCW-1:0] q_fc,
    output logic [AW-1:0]  q_addr,
    output logic [DW-1:0]  q_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_write <= 1'b0;
            q_byte  <= 1'b0;
            q_fc    <= '0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (load) begin
            q_write <= in_write;
            q_byte  <= in_byte;
            q_fc    <= in_fc;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/abus_fsm.sv
module abus_fsm
    import abus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       quiet,
    input  logic       is_write,
    input  logic       hit,
    output seq_state_t state,
    output logic       accept,
    output logic       ready
);
    seq_state_t nxt;

    assign ready  = (state == ST_IDLE) && quiet;
    assign accept = req_valid && ready;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_ADDR;
            ST_ADDR:  nxt = is_write ? ST_ASRT : ST_WAIT;
            ST_ASRT:  nxt = ST_WDAT;
            ST_WDAT:  nxt = ST_WAIT;
            ST_WAIT:  if (hit) nxt = ST_LATCH;
            ST_LATCH: nxt = ST_END;
            ST_END:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/abus_resp.sv
module abus_resp
    import abus_pkg::*;
#(
    parameter int DW = ABUS_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic          capture,
    input  logic          is_write,
    input  term_t         term_in,
    input  logic [DW-1:0] din,
    output term_t         rsp,
    output logic [DW-1:0] rdata
);
    term_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            rsp   <= '0;
            rdata <= '0;
        end else begin
            if (sample) held <= term_in;
            if (capture) begin
                rsp   <= held;
                rdata <= is_write ? '0 : din;
            end
        end
    end
endmodule

// File: rtl/abus_master.sv
module abus_master
    import abus_pkg::*;
#(
    parameter int AW  = ABUS_AW,
    parameter int DW  = ABUS_DW,
    parameter int FCW = ABUS_FCW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic           req_byte,
    input  logic [FCW-1:0] req_fc,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic           done,
    output logic [DW-1:0]  rsp_rdata,
    output logic           rsp_port16,
    output logic           rsp_berr,
    output logic           rsp_exc,
    output logic           rsp_avec,
    output logic [AW-1:0]  bus_addr,
    output logic [FCW-1:0] bus_fc,
    output logic           bus_byte,
    output logic           bus_rw,
    output logic           bus_as,
    output logic           bus_ds,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_doe,
    input  logic [DW-1:0]  bus_din,
    input  logic [1:0]     bus_ack,
    input  logic           bus_berr,
    input  logic           bus_halt,
    input  logic           bus_avec
);
    seq_state_t state;
    logic       accept;
    logic       wr_q;
    logic       iack;
    logic       quiet;
    logic       hit;
    term_t      term_now;
    term_t      rsp;

    assign quiet = (bus_ack == 2'b00) && !bus_berr && !bus_avec;

    abus_req_reg #(.AW(AW), .DW(DW), .FCW(FCW)) u_req (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .in_write (req_write),
        .in_byte  (req_byte),
        .in_fc    (req_fc),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .q_write  (wr_q),
        .q_byte   (bus_byte),
        .q_fc     (bus_fc),
        .q_addr   (bus_addr),
        .q_wdata  (bus_dout)
    );

    assign iack     = (bus_fc == FC_CPU_SPACE) && !wr_q;
    assign hit      = term_hit(bus_ack, bus_berr, bus_avec, iack);
    assign term_now = term_decode(bus_ack, bus_berr, bus_halt, bus_avec, iack);

    abus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .quiet     (quiet),
        .is_write  (wr_q),
        .hit       (hit),
        .state     (state),
        .accept    (accept),
        .ready     (req_ready)
    );

    abus_resp #(.DW(DW)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .sample   ((state == ST_WAIT) && hit),
        .capture  (state == ST_LATCH),
        .is_write (wr_q),
        .term_in  (term_now),
        .din      (bus_din),
        .rsp      (rsp),
        .rdata    (rsp_rdata)
    );

    // Strobes decoded from the step the sequencer is in
    assign bus_as  = (state == ST_ASRT) || (state == ST_WDAT) ||
                     (state == ST_WAIT) || (state == ST_LATCH);
    assign bus_ds  = (state == ST_WAIT) || (state == ST_LATCH);
    assign bus_doe = wr_q && ((state == ST_WDAT) || (state == ST_WAIT) ||
                              (state == ST_LATCH));
    assign bus_rw  = !(wr_q && (state != ST_IDLE));
    assign done    = (state == ST_END);

    assign rsp_port16 = rsp.port16;
    assign rsp_berr   = rsp.berr;
    assign rsp_exc    = rsp.exc;
    assign rsp_avec   = rsp.avec;
endmodule

// File: rtl/abus_master_chk.sv
module abus_master_chk #(
    parameter int AW  = abus_pkg::ABUS_AW,
    parameter int FCW = abus_pkg::ABUS_FCW
) (
    input logic           clk,
    input logic           rst,
    input logic           done,
    input logic           rsp_berr,
    input logic           rsp_exc,
    input logic [AW-1:0]  bus_addr,
    input logic [FCW-1:0] bus_fc,
    input logic           bus_rw,
    input logic           bus_as,
    input logic           bus_ds,
    input logic           bus_doe,
    input logic [1:0]     bus_ack,
    input logic           bus_berr,
    input logic           bus_avec
);
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_fc)));

    assert_ds_needs_as_R4: assert property (@(posedge clk) disable iff (rst)
        bus_ds |-> bus_as);

    assert_rd_ds_with_as_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_as) && bus_rw) |-> bus_ds);

    assert_doe_only_write_R5: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> !bus_rw);

    assert_wr_ds_lag_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_ds) && !bus_rw) |-> ($past(bus_as, 2) && !$past(bus_as, 3)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_strobes_off_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_as && !bus_ds && !bus_doe));

    assert_exc_needs_berr_R8: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_exc) |-> rsp_berr);

    assert_start_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as) |-> $past((bus_ack == 2'b00) && !bus_berr && !bus_avec, 2));
endmodule

bind abus_master abus_master_chk #(.AW(AW), .FCW(FCW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .rsp_berr (rsp_berr),
    .rsp_exc  (rsp_exc),
    .bus_addr (bus_addr),
    .bus_fc   (bus_fc),
    .bus_rw   (bus_rw),
    .bus_as   (bus_as),
    .bus_ds   (bus_ds),
    .bus_doe  (bus_doe),
    .bus_ack  (bus_ack),
    .bus_berr (bus_berr),
    .bus_avec (bus_avec)
);

// File: tb/abus_master_tb.sv
`timescale 1ns/1ps
module abus_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [2:0]  req_fc = 3'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rsp_rdata;
    logic        rsp_port16, rsp_berr, rsp_exc, rsp_avec;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_byte, bus_rw, bus_as, bus_ds, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic [1:0]  bus_ack = 2'b00;
    logic        bus_berr = 1'b0, bus_halt = 1'b0, bus_avec = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    abus_master u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 running (m_s steps since accept), 2 latch, 3 end
    int          m_st = 0;
    int          m_s = 0;
    logic        m_wr = 0, m_byte = 0, m_iack = 0;
    logic [2:0]  m_fc = 0;
    logic [23:0] m_addr = 0;
    logic [15:0] m_wd = 0, m_rd = 0;
    logic        m_p16 = 0, m_berr = 0, m_exc = 0, m_av = 0;

    function automatic logic quiet_now();
        return (bus_ack == 2'b00) && !bus_berr && !bus_avec;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (req_valid && quiet_now()) begin
                    m_st = 1; m_s = 1;
                    m_wr = req_write; m_byte = req_byte; m_fc = req_fc;
                    m_addr = req_addr; m_wd = req_wdata;
                    m_iack = (req_fc == 3'b111) && !req_write;
                end
                1: begin
                    if (((!m_wr && m_s >= 2) || (m_wr && m_s >= 4)) &&
                        (bus_ack != 2'b00 || bus_berr || (bus_avec && m_iack))) begin
                        m_st = 2;
                        m_p16 = (bus_ack == 2'b11) || (bus_ack == 2'b01);
                        m_berr = bus_berr;
                        m_exc = bus_berr && bus_halt;
                        m_av = bus_avec && m_iack;
                    end else if (m_s < 1000) m_s++;
                end
                2: begin m_st = 3; m_rd = m_wr ? 16'h0 : bus_din; end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        logic e_as, e_ds, e_doe;
        e_as = 0; e_ds = 0; e_doe = 0;
        if (m_st == 1) begin
            if (!m_wr) begin e_as = (m_s >= 2); e_ds = (m_s >= 2); end
            else begin e_as = (m_s >= 2); e_doe = (m_s >= 3); e_ds = (m_s >= 4); end
        end else if (m_st == 2) begin
            e_as = 1; e_ds = 1; e_doe = m_wr;
        end
        if (rst) begin
            chk("R1 as/ds/doe/done in reset", {bus_as, bus_ds, bus_doe, done}, 4'b0000);
        end else begin
            chk("R3 bus_as", bus_as, e_as);
            chk(m_wr ? "R5 bus_ds" : "R4 bus_ds", bus_ds, e_ds);
            chk(m_wr ? "R5 bus_doe" : "R4 bus_doe", bus_doe, e_doe);
            chk("R6 done", done, m_st == 3);
            chk((m_st == 0 && quiet_now()) ? "R1 req_ready" : "R10 req_ready",
                req_ready, m_st == 0 && quiet_now());
            if (m_st != 0) begin
                chk("R2 bus_addr", bus_addr, m_addr);
                chk("R2 bus_fc", bus_fc, m_fc);
                chk("R2 bus_byte", bus_byte, m_byte);
                chk("R2 bus_rw", bus_rw, !m_wr);
            end
            if (e_doe) chk("R5 bus_dout", bus_dout, m_wd);
            if (m_st == 3) begin
                chk("R6 rsp_rdata", rsp_rdata, m_rd);
                chk("R7 rsp_port16", rsp_port16, m_p16);
                chk("R8 rsp_berr", rsp_berr, m_berr);
                chk("R8 rsp_exc", rsp_exc, m_exc);
                chk("R9 rsp_avec", rsp_avec, m_av);
            end
        end
    end

    task automatic run_cycle(input logic wr, input logic sz, input logic [2:0] fc,
                             input logic [23:0] a, input logic [15:0] wd, input int dly,
                             input logic [1:0] ak, input logic b, input logic h,
                             input logic av, input logic [15:0] di,
                             input logic ign, input int linger);
        @(negedge clk);
        req_write = wr; req_byte = sz; req_fc = fc; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (dly) @(negedge clk);
        if (ign) begin
            bus_avec = 1'b1;
            repeat (4) begin
                @(negedge clk);
                chk("R9 avec ignored outside iack", {bus_as, done}, 2'b10);
            end
        end
        bus_din = di; bus_ack = ak; bus_berr = b; bus_halt = h; bus_avec = av;
        while (!done) @(negedge clk);
        if (linger > 0) begin
            req_valid = 1'b1;
            repeat (linger) begin
                @(negedge clk);
                chk("R10 no start while ack held", {bus_as, req_ready}, 2'b00);
            end
            req_valid = 1'b0;
        end
        bus_ack = 2'b00; bus_berr = 1'b0; bus_halt = 1'b0; bus_avec = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req_ready in reset", req_ready, 1'b1);
        rst = 1'b0;
        // R4 R6 R7: read, 16-bit ack, immediate
        run_cycle(0, 0, 3'b101, 24'hABCDEF, 16'h0, 0, 2'b11, 0, 0, 0, 16'hBEEF, 0, 0);
        // R7: read, 8-bit port, delayed ack
        run_cycle(0, 1, 3'b001, 24'h000123, 16'h0, 5, 2'b10, 0, 0, 0, 16'h00A5, 0, 0);
        // R5 R7: byte write, all 16 lines driven, ack 01
        run_cycle(1, 1, 3'b001, 24'h7FFFFE, 16'hC35A, 0, 2'b01, 0, 0, 0, 16'h1111, 0, 0);
        // R5: word write, late ack
        run_cycle(1, 0, 3'b101, 24'hFFFFFF, 16'h8001, 3, 2'b11, 0, 0, 0, 16'h0, 0, 0);
        // R8: bus error alone
        run_cycle(0, 0, 3'b010, 24'h100000, 16'h0, 2, 2'b00, 1, 0, 0, 16'h2222, 0, 0);
        // R8: bus error with halt on a write
        run_cycle(1, 0, 3'b110, 24'h200000, 16'h5555, 1, 2'b00, 1, 1, 0, 16'h0, 0, 0);
        // R9: autovector ends an interrupt-acknowledge read
        run_cycle(0, 1, 3'b111, 24'hFFFFF5, 16'h0, 1, 2'b00, 0, 0, 1, 16'h3333, 0, 0);
        // R9: autovector ignored in a data read, ack ends it later
        run_cycle(0, 0, 3'b101, 24'h004000, 16'h0, 0, 2'b11, 0, 0, 1, 16'h4444, 1, 0);
        // R9: autovector ignored in a CPU-space write
        run_cycle(1, 0, 3'b111, 24'h00F000, 16'h9999, 0, 2'b10, 0, 0, 1, 16'h0, 1, 0);
        // R10: ack held after done while a request waits
        run_cycle(0, 0, 3'b001, 24'h012345, 16'h0, 1, 2'b11, 0, 0, 0, 16'h6789, 0, 4);
        // R10: the waiting request then runs
        run_cycle(0, 0, 3'b001, 24'h054321, 16'h0, 0, 2'b10, 0, 0, 0, 16'h0F0F, 0, 0);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule